// File: doc/BRIEF.md
# Banked Memory Decoder with Door-Guarded Settings RAM

This block decodes the 16-bit address bus of an 8-bit CPU into chip selects for a banked program ROM, a battery-backed 8 KB work RAM, a bank latch, a switch-read port and an I/O board strobe. The program ROM holds up to 8 MB. The CPU sees it through a 16 KB window at 0x4000-0x7FFF, which shows whichever bank the bank latch holds, and through a fixed 32 KB area at 0x8000-0xFFFF, which always shows the top 32 KB of ROM so that the reset vectors are reachable.

The bank number is 9 bits wide and is written as two bytes. A write to 0x2000 loads bits 7:0. A write to 0x2001 loads bit 8 from data bit 0. Each of these writes also produces a one-cycle feed pulse for an external supervisor watchdog. The top 512 bytes of RAM, 0x1E00-0x1FFF, hold settings. The RAM write enable is withheld for that range unless the memory-protect input, which comes from the cabinet door switch, is high. Reads of that range are never blocked.

The memories themselves are outside the block. It drives only their selects, the RAM write enable and the composed ROM address.

Top module: `banked_mem_dec`

## Requirements
- R1: A valid access to 0x0000-0x1FFF asserts ram_cs_o. ram_we_o is asserted only together with ram_cs_o, and only on a write.
- R2: A write to 0x1E00-0x1FFF asserts ram_we_o only while mem_prot_i is 1. Writes below 0x1E00 ignore mem_prot_i. Reads in 0x1E00-0x1FFF always assert ram_cs_o.
- R3: Reset sets the bank to 0. A write to 0x2000 loads bank[7:0] from data_i[7:0]. A write to 0x2001 loads bank[8] from data_i[0] and ignores data_i[7:1]. The new bank is used from the next cycle onward.
- R4: A valid read of 0x4000-0x7FFF asserts rom_cs_o, with rom_addr_o = {bank, addr_i[13:0]}. Writes anywhere in 0x4000-0xFFFF never assert rom_cs_o.
- R5: A valid read of 0x8000-0xFFFF asserts rom_cs_o, with rom_addr_o = {8'hFF, addr_i[14:0]}, whatever the bank.
- R6: wdog_feed_o is high in the cycle after each cycle in which bank_le_o is high, and low at all other times. bank_le_o is high during any valid write to 0x2000 or 0x2001.
- R7: A valid read of 0x2002 asserts sw_rd_o. A write to 0x2002 asserts no output and changes neither the bank nor wdog_feed_o.
- R8: Any valid access to 0x3000-0x3FFF asserts io_strb_o.
- R9: At most one of ram_cs_o, rom_cs_o, bank_le_o, sw_rd_o and io_strb_o is high at a time. All of them are low while valid_i is low, and a write with valid_i low changes no state. Addresses 0x2003-0x2FFF select nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Bus cycle carries a valid address |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | CPU address |
| data_i | input | 8 | CPU write data |
| mem_prot_i | input | 1 | Door switch; 1 permits settings writes |
| ram_cs_o | output | 1 | Work RAM select |
| ram_we_o | output | 1 | Work RAM write enable |
| rom_cs_o | output | 1 | Program ROM select |
| rom_addr_o | output | 23 | Composed ROM byte address |
| bank_le_o | output | 1 | Bank latch load enable |
| sw_rd_o | output | 1 | Switch port read enable |
| io_strb_o | output | 1 | I/O board address-valid strobe |
| wdog_feed_o | output | 1 | One-cycle watchdog feed pulse |

## Verification
A bank write is followed at once by a read of the banked window. In that one cycle, the feed pulse left by the write overlaps a ROM fetch that must already use the new bank. The bench writes the bank byte and reads 0x4123 or 0x7FFF on the very next cycle, then checks the feed pulse and the composed address in that same cycle. It also writes the bank twice in a row to show that the feed pulse stays high for two cycles while the address follows the second value. The settings guard is judged in the same cycle as the write, by holding mem_prot_i low and then high for writes at the lower and upper edges of the protected range.

// File: rtl/mem_dec_pkg.sv
package mem_dec_pkg;
  localparam int CPU_AW = 16;
  localparam int WIN_W  = 14;  // banked window size, log2
  localparam int FIX_W  = 15;  // fixed upper area size, log2

  localparam logic [CPU_AW-1:0] BANK_LO_ADDR = 16'h2000;
  localparam logic [CPU_AW-1:0] BANK_HI_ADDR = 16'h2001;
  localparam logic [CPU_AW-1:0] SWITCH_ADDR  = 16'h2002;
  localparam logic [3:0]        IO_PAGE      = 4'h3;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_RAM,
    RG_BANK_LO,
    RG_BANK_HI,
    RG_SWITCH,
    RG_IO,
    RG_ROM_WIN,
    RG_ROM_FIX
  } region_e;
endpackage

// File: rtl/mem_region_dec.sv
module mem_region_dec
  import mem_dec_pkg::*;
#(
  parameter int RAM_AW = 13
) (
  input  logic [CPU_AW-1:0] addr_i,
  output region_e           region_o
);
  always_comb begin
    if (addr_i[CPU_AW-1:RAM_AW] == '0)       region_o = RG_RAM;
    else if (addr_i == BANK_LO_ADDR)         region_o = RG_BANK_LO;
    else if (addr_i == BANK_HI_ADDR)         region_o = RG_BANK_HI;
    else if (addr_i == SWITCH_ADDR)          region_o = RG_SWITCH;
    else if (addr_i[15:12] == IO_PAGE)       region_o = RG_IO;
    else if (addr_i[15:14] == 2'b01)         region_o = RG_ROM_WIN;
    else if (addr_i[15])                     region_o = RG_ROM_FIX;
    else                                     region_o = RG_NONE;
  end
endmodule

// File: rtl/nvram_guard.sv
module nvram_guard #(
  parameter int RAM_AW  = 13,
  parameter int PROT_AW = 9
) (
  input  logic              ram_sel_i,
  input  logic              we_i,
  input  logic [RAM_AW-1:0] ram_off_i,
  input  logic              mem_prot_i,
  output logic              ram_we_o
);
  logic in_prot;

  // settings area is the top 2**PROT_AW bytes of RAM
  assign in_prot  = &ram_off_i[RAM_AW-1:PROT_AW];
  assign ram_we_o = ram_sel_i & we_i & (~in_prot | mem_prot_i);
endmodule

// File: rtl/bank_reg.sv
module bank_reg #(
  parameter int BANK_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [7:0]        data_i,
  output logic [BANK_W-1:0] bank_o,
  output logic              feed_o
);
  generate
    if (BANK_W > 8) begin : g_two_byte
      localparam int HI_W = BANK_W - 8;
      logic [7:0]      lo_q;
      logic [HI_W-1:0] hi_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          lo_q <= '0;
          hi_q <= '0;
        end else begin
          if (wr_lo_i) lo_q <= data_i;
          if (wr_hi_i) hi_q <= data_i[HI_W-1:0];
        end
      end
      assign bank_o = {hi_q, lo_q};
    end else begin : g_one_byte
      logic [BANK_W-1:0] lo_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      lo_q <= '0;
        else if (wr_lo_i) lo_q <= data_i[BANK_W-1:0];
      end
      assign bank_o = lo_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) feed_o <= 1'b0;
    else         feed_o <= wr_lo_i | wr_hi_i;
  end
endmodule

// File: rtl/banked_mem_dec.sv
module banked_mem_dec
  import mem_dec_pkg::*;
#(
  parameter int ROM_ADDR_W = 23,
  parameter int RAM_AW     = 13,
  parameter int PROT_AW    = 9
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic                  we_i,
  input  logic [15:0]           addr_i,
  input  logic [7:0]            data_i,
  input  logic                  mem_prot_i,
  output logic                  ram_cs_o,
  output logic                  ram_we_o,
  output logic                  rom_cs_o,
  output logic [ROM_ADDR_W-1:0] rom_addr_o,
  output logic                  bank_le_o,
  output logic                  sw_rd_o,
  output logic                  io_strb_o,
  output logic                  wdog_feed_o
);
  localparam int BANK_W = ROM_ADDR_W - WIN_W;
  localparam int TOP_W  = ROM_ADDR_W - FIX_W;

  region_e           region;
  logic              ram_sel;
  logic              wr_lo, wr_hi;
  logic [BANK_W-1:0] bank;

  mem_region_dec #(.RAM_AW(RAM_AW)) u_region (
    .addr_i  (addr_i),
    .region_o(region)
  );

  assign ram_sel   = valid_i & (region == RG_RAM);
  assign wr_lo     = valid_i & we_i & (region == RG_BANK_LO);
  assign wr_hi     = valid_i & we_i & (region == RG_BANK_HI);

  nvram_guard #(.RAM_AW(RAM_AW), .PROT_AW(PROT_AW)) u_guard (
    .ram_sel_i (ram_sel),
    .we_i      (we_i),
    .ram_off_i (addr_i[RAM_AW-1:0]),
    .mem_prot_i(mem_prot_i),
    .ram_we_o  (ram_we_o)
  );

  bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_lo_i(wr_lo),
    .wr_hi_i(wr_hi),
    .data_i (data_i),
    .bank_o (bank),
    .feed_o (wdog_feed_o)
  );

  assign ram_cs_o  = ram_sel;
  assign bank_le_o = wr_lo | wr_hi;
  assign rom_cs_o  = valid_i & ~we_i & ((region == RG_ROM_WIN) | (region == RG_ROM_FIX));
  assign sw_rd_o   = valid_i & ~we_i & (region == RG_SWITCH);
  assign io_strb_o = valid_i & (region == RG_IO);

  // upper half maps to the last 32 KB of ROM regardless of bank
  assign rom_addr_o = addr_i[15] ? {{TOP_W{1'b1}}, addr_i[FIX_W-1:0]}
                                 : {bank, addr_i[WIN_W-1:0]};
endmodule

// File: rtl/banked_mem_dec_chk.sv
module banked_mem_dec_chk #(
  parameter int ROM_ADDR_W = 23,
  parameter int RAM_AW     = 13,
  parameter int PROT_AW    = 9
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  valid_i,
  input logic                  we_i,
  input logic [15:0]           addr_i,
  input logic                  mem_prot_i,
  input logic                  ram_cs_o,
  input logic                  ram_we_o,
  input logic                  rom_cs_o,
  input logic [ROM_ADDR_W-1:0] rom_addr_o,
  input logic                  bank_le_o,
  input logic                  sw_rd_o,
  input logic                  io_strb_o,
  input logic                  wdog_feed_o
);
  localparam int RAM_TOP  = 1 << RAM_AW;
  localparam int PROT_BOT = RAM_TOP - (1 << PROT_AW);

  logic prot_hit;
  assign prot_hit = valid_i && (int'(addr_i) < RAM_TOP) && (int'(addr_i) >= PROT_BOT);

  AST_SINGLE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ram_cs_o, rom_cs_o, bank_le_o, sw_rd_o, io_strb_o}) <= 1); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !(ram_cs_o || ram_we_o || rom_cs_o || bank_le_o || sw_rd_o || io_strb_o)); // R9
  AST_WE_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_cs_o && we_i)); // R1
  AST_PROT_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_hit && !mem_prot_i) |-> !ram_we_o); // R2
  AST_PROT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_hit && !we_i) |-> ram_cs_o); // R2
  AST_NO_ROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> !rom_cs_o); // R4
  AST_FIX_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_cs_o && addr_i[15]) |-> (&rom_addr_o[ROM_ADDR_W-1:15])); // R5
  AST_FEED_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_le_o |=> wdog_feed_o); // R6
  AST_FEED_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_feed_o |-> $past(bank_le_o)); // R6
endmodule

bind banked_mem_dec banked_mem_dec_chk #(
  .ROM_ADDR_W(ROM_ADDR_W),
  .RAM_AW    (RAM_AW),
  .PROT_AW   (PROT_AW)
) u_chk (.*);

// File: tb/sim_banked_mem_dec.sv
module sim_banked_mem_dec;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        valid_i, we_i, mem_prot_i;
  logic [15:0] addr_i;
  logic [7:0]  data_i;
  logic        ram_cs_o, ram_we_o, rom_cs_o, bank_le_o, sw_rd_o, io_strb_o, wdog_feed_o;
  logic [22:0] rom_addr_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  banked_mem_dec u0 (.*);

  // {addr, we, prot, exp {ram_cs, ram_we, rom_cs, sw_rd, io_strb}}
  localparam int NV = 16;
  localparam logic [22:0] VEC [NV] = '{
    {16'h0000, 1'b0, 1'b0, 5'b10000},
    {16'h1DFF, 1'b1, 1'b0, 5'b11000},
    {16'h1E00, 1'b1, 1'b0, 5'b10000},
    {16'h1FFF, 1'b1, 1'b1, 5'b11000},
    {16'h1FFF, 1'b0, 1'b0, 5'b10000},
    {16'h2002, 1'b0, 1'b0, 5'b00010},
    {16'h2002, 1'b1, 1'b0, 5'b00000},
    {16'h2003, 1'b0, 1'b0, 5'b00000},
    {16'h3000, 1'b1, 1'b0, 5'b00001},
    {16'h3FFF, 1'b0, 1'b0, 5'b00001},
    {16'h4000, 1'b0, 1'b0, 5'b00100},
    {16'h7FFF, 1'b0, 1'b0, 5'b00100},
    {16'h8000, 1'b0, 1'b1, 5'b00100},
    {16'hFFFF, 1'b0, 1'b0, 5'b00100},
    {16'h5234, 1'b1, 1'b1, 5'b00000},
    {16'h0100, 1'b1, 1'b0, 5'b11000}
  };

  function automatic logic [22:0] exp_rom(input logic [15:0] a, input logic [8:0] b);
    return a[15] ? {8'hFF, a[14:0]} : {b, a[13:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic w, input logic [15:0] a,
                       input logic [7:0] d, input logic p);
    @(negedge clk_i);
    valid_i = v; we_i = w; addr_i = a; data_i = d; mem_prot_i = p;
    #1;
  endtask

  function automatic logic [5:0] sels();
    return {ram_cs_o, ram_we_o, rom_cs_o, bank_le_o, sw_rd_o, io_strb_o};
  endfunction

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    valid_i = 1'b0; we_i = 1'b0; addr_i = '0; data_i = '0; mem_prot_i = 1'b0;
    repeat (3) @(negedge clk_i);
    #1;
    check("R9 reset idle selects", {26'd0, sels()}, 32'd0);
    check("R6 reset feed", {31'd0, wdog_feed_o}, 32'd0);
    drive(1'b1, 1'b0, 16'h4000, 8'h00, 1'b0);
    check("R3 reset bank zero", {9'd0, rom_addr_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // table walk, bank 0
    for (int i = 0; i < NV; i++) begin
      logic [15:0] a;
      logic [4:0]  e;
      a = VEC[i][22:7];
      e = VEC[i][4:0];
      drive(1'b1, VEC[i][6], a, 8'h5A, VEC[i][5]);
      check($sformatf("R1/R2/R4/R5/R7/R8 row %0d flags", i),
            {27'd0, ram_cs_o, ram_we_o, rom_cs_o, sw_rd_o, io_strb_o}, {27'd0, e});
      check($sformatf("R9 row %0d no bank latch", i), {31'd0, bank_le_o}, 32'd0);
      if (e[2]) check($sformatf("R4/R5 row %0d rom addr", i), {9'd0, rom_addr_o},
                      {9'd0, exp_rom(a, 9'h000)});
    end
    check("R6 no feed after table", {31'd0, wdog_feed_o}, 32'd0);

    // bank low write then window read next cycle
    drive(1'b1, 1'b1, 16'h2000, 8'hA5, 1'b0);
    check("R6 bank latch enable", {26'd0, sels()}, 32'b000100);
    check("R6 feed not early", {31'd0, wdog_feed_o}, 32'd0);
    drive(1'b1, 1'b0, 16'h4123, 8'h00, 1'b0);
    check("R6 feed after low write", {31'd0, wdog_feed_o}, 32'd1);
    check("R3 new bank low used", {9'd0, rom_addr_o}, {9'd0, exp_rom(16'h4123, 9'h0A5)});
    drive(1'b0, 1'b0, 16'h0000, 8'h00, 1'b0);
    check("R6 feed single cycle", {31'd0, wdog_feed_o}, 32'd0);

    // bank high write
    drive(1'b1, 1'b1, 16'h2001, 8'h01, 1'b0);
    drive(1'b1, 1'b0, 16'h7FFF, 8'h00, 1'b0);
    check("R6 feed after high write", {31'd0, wdog_feed_o}, 32'd1);
    check("R3 high bit loaded", {9'd0, rom_addr_o}, 32'h0069_7FFF);
    drive(1'b1, 1'b0, 16'hC000, 8'h00, 1'b0);
    check("R5 fixed ignores bank", {9'd0, rom_addr_o}, 32'h007F_C000);

    // high write ignores data bits 7:1
    drive(1'b1, 1'b1, 16'h2001, 8'hFE, 1'b0);
    drive(1'b1, 1'b0, 16'h4000, 8'h00, 1'b0);
    check("R3 high write upper data ignored", {9'd0, rom_addr_o}, 32'h0029_4000);

    // switch port write: no state change
    drive(1'b1, 1'b1, 16'h2002, 8'h33, 1'b0);
    check("R7 switch write no selects", {26'd0, sels()}, 32'd0);
    drive(1'b1, 1'b0, 16'h4000, 8'h00, 1'b0);
    check("R7 switch write keeps bank", {9'd0, rom_addr_o}, 32'h0029_4000);
    check("R7 switch write no feed", {31'd0, wdog_feed_o}, 32'd0);

    // write with valid low
    drive(1'b0, 1'b1, 16'h2000, 8'h11, 1'b0);
    check("R9 invalid write no selects", {26'd0, sels()}, 32'd0);
    drive(1'b1, 1'b0, 16'h4000, 8'h00, 1'b0);
    check("R9 invalid write keeps bank", {9'd0, rom_addr_o}, 32'h0029_4000);
    check("R9 invalid write no feed", {31'd0, wdog_feed_o}, 32'd0);

    // back-to-back bank writes
    drive(1'b1, 1'b1, 16'h2000, 8'h03, 1'b0);
    drive(1'b1, 1'b1, 16'h2000, 8'h04, 1'b0);
    check("R6 feed during second write", {31'd0, wdog_feed_o}, 32'd1);
    drive(1'b1, 1'b0, 16'h4000, 8'h00, 1'b0);
    check("R6 feed held second cycle", {31'd0, wdog_feed_o}, 32'd1);
    check("R3 second write wins", {9'd0, rom_addr_o}, 32'h0001_0000);
    drive(1'b0, 1'b0, 16'h0000, 8'h00, 1'b0);
    check("R6 feed drops", {31'd0, wdog_feed_o}, 32'd0);

    // door toggling at the protected edge
    drive(1'b1, 1'b1, 16'h1E00, 8'h00, 1'b1);
    check("R2 protected write door open", {31'd0, ram_we_o}, 32'd1);
    drive(1'b1, 1'b1, 16'h1E00, 8'h00, 1'b0);
    check("R2 protected write door shut", {31'd0, ram_we_o}, 32'd0);
    check("R2 protected cs kept", {31'd0, ram_cs_o}, 32'd1);

    // reset mid-run restores bank 0
    @(negedge clk_i);
    rst_ni = 1'b0;
    valid_i = 1'b1; we_i = 1'b0; addr_i = 16'h4000;
    #1;
    check("R3 reset clears bank", {9'd0, rom_addr_o}, 32'd0);
    check("R6 reset clears feed", {31'd0, wdog_feed_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    valid_i = 1'b0;
    @(negedge clk_i);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule